// File: doc/BRIEF.md
# Serial Hold Pause Qualifier

This block sits in front of the shift engine of a serial slave port. It lets the host freeze a transfer part way through and pick it up later with nothing lost. The inputs are chip select, the serial clock and an active-low hold request. They arrive asynchronously and are brought into the system clock domain by a synchronizer.

The block decides when the port is paused. It emits one-cycle enables for qualified rising and falling serial-clock edges, and it forces the data output to high impedance when needed. Entering or leaving the paused state is only accepted while the serial clock is low. A hold request that falls while the clock is high waits for the next falling edge. A hold release that arrives while the clock is high is not accepted until the clock is seen low.

The output override behaves differently. It follows a low hold request at once, whatever the pause qualification. A built-in bit-position counter counts qualified rising edges, so the engine resumes at the exact bit where the pause began. Chip select outranks everything else.

Top module: `hold_pause_ctrl`

## Requirements
- R1: During and straight after reset, paused_o=0, both edge enables are 0, so_hiz_o=1 and bit_pos_o=0.
- R2: With chip select low and the synchronized clock low, a low hold request sets paused_o.
- R3: A hold request that goes low while the clock is high leaves paused_o at 0 until the next falling clock edge, which sets paused_o. That falling edge produces no falling-edge enable.
- R4: While paused, paused_o clears only when the hold request is high and the clock is low. A release seen only while the clock is high keeps paused_o at 1.
- R5: While paused, serial clock edges produce no rise or fall enables, and bit_pos_o holds its value.
- R6: so_hiz_o is 1 whenever chip select is high, the hold request is low, or the block is paused, and is 0 otherwise.
- R7: Chip select high clears paused_o and returns bit_pos_o to 0, including in the middle of a pause.
- R8: Each qualified rising edge pulses sck_rise_en_o for one cycle and advances bit_pos_o by one (modulo 2^CNT_W). After a resume, counting continues from the value held during the pause.
- R9: A change on any input is reflected in paused_o, so_hiz_o, the edge enables and bit_pos_o on the third rising system-clock edge after it is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| hold_ni | input | 1 | Hold request, active low, asynchronous |
| paused_o | output | 1 | Port is paused |
| sck_rise_en_o | output | 1 | One-cycle enable for a qualified rising clock edge |
| sck_fall_en_o | output | 1 | One-cycle enable for a qualified falling clock edge |
| so_hiz_o | output | 1 | Force serial data output to high impedance |
| bit_pos_o | output | CNT_W | Count of qualified rising edges in the current selection |

## Verification
Every result lands three system-clock edges after the input change. Two of those edges are synchronizer stages and one is the output register. The vector walk therefore drives inputs on a falling system edge, lets five rising edges pass, and samples on a falling edge. The counter and the bench's own tally of fall-enable pulses both accumulate over the whole walk, so a missing or extra pulse shows up in a later vector. A directed test checks the exact cycle: after a hold request, paused_o must still be 0 after two rising edges and must be 1 after the third.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    typedef struct packed {
        logic sck_prev;
        logic paused;
        logic rise_en;
        logic fall_en;
        logic so_hiz;
    } hpc_state_t;

    localparam hpc_state_t HPC_RESET = '{
        sck_prev: 1'b0,
        paused:   1'b0,
        rise_en:  1'b0,
        fall_en:  1'b0,
        so_hiz:   1'b1
    };

endpackage

// File: rtl/hpc_sync.sv
module hpc_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] in_w;
        if (s == 0) begin : g_first
            assign in_w = async_i;
        end else begin : g_next
            assign in_w = chain_q[s-1];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= RST_VAL;
            else         chain_q[s] <= in_w;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/hpc_qualifier.sv
module hpc_qualifier
    import hpc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_n_s,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic rise_en_d_o,
    output logic paused_o,
    output logic rise_en_o,
    output logic fall_en_o,
    output logic so_hiz_o
);

    hpc_state_t st_d, st_q;

    always_comb begin
        logic rise, fall;
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        rise          = sck_s & ~st_q.sck_prev;
        fall          = ~sck_s & st_q.sck_prev;
        if (cs_n_s) begin
            st_d.paused = 1'b0;
        end else if (!sck_s) begin
            // pause state may change only while the serial clock is low
            st_d.paused = ~hold_n_s;
        end
        st_d.rise_en = rise & ~cs_n_s & ~st_q.paused;
        st_d.fall_en = fall & ~cs_n_s & ~st_d.paused;
        st_d.so_hiz  = cs_n_s | ~hold_n_s | st_d.paused;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= HPC_RESET;
        else         st_q <= st_d;
    end

    assign rise_en_d_o = st_d.rise_en;
    assign paused_o    = st_q.paused;
    assign rise_en_o   = st_q.rise_en;
    assign fall_en_o   = st_q.fall_en;
    assign so_hiz_o    = st_q.so_hiz;

    a_r2_enter_on_low_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_n_s && !sck_s && !hold_n_s) |=> st_q.paused);

    a_r4_keep_while_clock_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_n_s && sck_s) |=> (st_q.paused == $past(st_q.paused)));

    a_r5_no_edges_when_paused: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.paused && $past(st_q.paused)) |-> (!st_q.rise_en && !st_q.fall_en));

    a_r6_hiz_when_paused: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.paused |-> st_q.so_hiz);

    a_r7_select_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n_s |=> (!st_q.paused && st_q.so_hiz));

endmodule

// File: rtl/hpc_bitpos.sv
module hpc_bitpos #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    a_r5_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !inc_i) |=> $stable(cnt_q));

    a_r7_count_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/hold_pause_ctrl.sv
module hold_pause_ctrl #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cs_ni,
    input  logic             sck_i,
    input  logic             hold_ni,
    output logic             paused_o,
    output logic             sck_rise_en_o,
    output logic             sck_fall_en_o,
    output logic             so_hiz_o,
    output logic [CNT_W-1:0] bit_pos_o
);

    localparam int NSIG = 3;
    // bit order: {cs_n, sck, hold_n}
    localparam logic [NSIG-1:0] SYNC_RST = 3'b101;

    logic [NSIG-1:0] raw_w, sync_w;
    logic            rise_en_d;

    assign raw_w = {cs_ni, sck_i, hold_ni};

    hpc_sync #(
        .WIDTH   (NSIG),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_w),
        .sync_o  (sync_w)
    );

    hpc_qualifier u_qual (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cs_n_s      (sync_w[2]),
        .sck_s       (sync_w[1]),
        .hold_n_s    (sync_w[0]),
        .rise_en_d_o (rise_en_d),
        .paused_o    (paused_o),
        .rise_en_o   (sck_rise_en_o),
        .fall_en_o   (sck_fall_en_o),
        .so_hiz_o    (so_hiz_o)
    );

    hpc_bitpos #(
        .CNT_W (CNT_W)
    ) u_pos (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (sync_w[2]),
        .inc_i  (rise_en_d),
        .cnt_o  (bit_pos_o)
    );

    a_r8_rise_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sck_rise_en_o && !$past(sync_w[2])) |-> (bit_pos_o == $past(bit_pos_o) + 1'b1));

endmodule

// File: tb/hold_pause_ctrl_bench.sv
`timescale 1ns/1ps
module hold_pause_ctrl_bench;

    localparam int CNT_W = 8;
    localparam int NV    = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1;
    logic paused, rise_en, fall_en, so_hiz;
    logic [CNT_W-1:0] pos;

    int n_vec = 0;
    int n_bad = 0;
    int fall_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hold_pause_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_hold_pause_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .hold_ni(hold_n),
        .paused_o(paused), .sck_rise_en_o(rise_en), .sck_fall_en_o(fall_en),
        .so_hiz_o(so_hiz), .bit_pos_o(pos)
    );

    always @(negedge clk) if (rst_n && fall_en) fall_seen++;

    // {cs_n, sck, hold_n, exp_paused, exp_hiz, exp_pos[3:0], exp_falls[3:0]}
    localparam logic [12:0] VEC [NV] = '{
        {3'b101, 2'b01, 4'd0, 4'd0},  // 0  deselected
        {3'b001, 2'b00, 4'd0, 4'd0},  // 1  selected, idle
        {3'b011, 2'b00, 4'd1, 4'd0},  // 2  R8 rise
        {3'b001, 2'b00, 4'd1, 4'd1},  // 3  fall
        {3'b011, 2'b00, 4'd2, 4'd1},  // 4  rise
        {3'b010, 2'b01, 4'd2, 4'd1},  // 5  R3 hold low, clock high: deferred
        {3'b000, 2'b11, 4'd2, 4'd1},  // 6  R3 pause at fall, no fall enable
        {3'b010, 2'b11, 4'd2, 4'd1},  // 7  R5 rise ignored
        {3'b000, 2'b11, 4'd2, 4'd1},  // 8  R5 fall ignored
        {3'b011, 2'b11, 4'd2, 4'd1},  // 9  R4 release with clock high
        {3'b001, 2'b00, 4'd2, 4'd2},  // 10 R4 resume
        {3'b011, 2'b00, 4'd3, 4'd2},  // 11 R8 continues from held count
        {3'b000, 2'b11, 4'd3, 4'd2},  // 12 R2 pause at fall with hold low
        {3'b010, 2'b11, 4'd3, 4'd2},  // 13 R5
        {3'b001, 2'b00, 4'd3, 4'd3},  // 14 R4 resume on falling edge
        {3'b011, 2'b00, 4'd4, 4'd3},  // 15 R8
        {3'b000, 2'b11, 4'd4, 4'd3},  // 16 pause
        {3'b100, 2'b01, 4'd0, 4'd3},  // 17 R7 deselect while paused
        {3'b000, 2'b11, 4'd0, 4'd3},  // 18 R2 select with hold low
        {3'b001, 2'b00, 4'd0, 4'd3},  // 19 R4 release
        {3'b011, 2'b00, 4'd1, 4'd3}   // 20 R8
    };

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin : watchdog
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        cycles(3);
        @(negedge clk);
        check("R1 paused", paused, 0);
        check("R1 so_hiz", so_hiz, 1);
        check("R1 rise_en", rise_en, 0);
        check("R1 fall_en", fall_en, 0);
        check("R1 bit_pos", pos, 0);
        rst_n = 1'b1;
        cycles(4);
        @(negedge clk);
        check("R1 after release so_hiz", so_hiz, 1);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {cs_n, sck, hold_n} = VEC[v][12:10];
            cycles(5);
            @(negedge clk);
            check($sformatf("R6 v%0d so_hiz", v), so_hiz, VEC[v][8]);
            check($sformatf("R2 R4 v%0d paused", v), paused, VEC[v][9]);
            check($sformatf("R8 R5 v%0d bit_pos", v), pos, VEC[v][7:4]);
            check($sformatf("R3 v%0d fall enables", v), fall_seen, VEC[v][3:0]);
        end

        // R9: exact latency of a pause request; state is selected, clock high, count 1
        @(negedge clk); sck = 1'b0;
        cycles(5);
        @(negedge clk); hold_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check("R9 paused before third edge", paused, 0);
        check("R9 so_hiz before third edge", so_hiz, 0);
        @(posedge clk); #1;
        check("R9 paused on third edge", paused, 1);
        check("R9 so_hiz on third edge", so_hiz, 1);

        // R9: rise enable is a single pulse on the third edge
        @(negedge clk); hold_n = 1'b1;
        cycles(5);
        @(negedge clk); sck = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R9 rise_en before third edge", rise_en, 0);
        @(posedge clk); #1;
        check("R9 R8 rise_en pulse", rise_en, 1);
        check("R9 R8 bit_pos same edge", pos, 2);
        @(posedge clk); #1;
        check("R8 rise_en one cycle", rise_en, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule